// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Emulator

This block is a synthesizable stand-in for an eight-channel, 16-bit converter that samples all of its channels at one instant and returns the results over a shared parallel bus. A host-side controller can be tested against it in simulation or on a board without the real converter. A rising edge on the shared convert-start input captures a code for every channel at the same moment. The emulator then raises busy for a fixed number of clock cycles. When busy falls, the host reads the eight codes in channel order, one word per falling edge of the read strobe while chip select is low. A flag marks the word that belongs to channel 1.

Each channel code is a 16-bit two's-complement value formed from a base, a per-channel step and, in ramp mode, a per-conversion step. This makes every word predictable for the host's own checks. A parameter selects what happens after channel 8 has been read: the index either wraps back to channel 1 or holds on channel 8.

The conversion controller is a three-state machine:
- IDLE is entered from reset. On an accepted convert edge it moves to CONVERT.
- In CONVERT, busy is high while a down-counter runs. When the counter expires the machine moves to READY.
- READY moves back to CONVERT on the next accepted convert edge.

An edge is accepted only in IDLE or READY.

Top module: `sadc_emu`

## Requirements
- R1: While reset is asserted (rst_n low), and just after it is released, busy is 0, the data bus is 0x0000 and the channel-1 flag is 0.
- R2: A low-to-high change of conv_start, seen at a clock edge while busy is low, makes busy read 1 after that edge. Busy then stays 1 for exactly CONV_CYCLES clock cycles (default 200) and returns to 0.
- R3: A convert-start rising edge while busy is high is ignored. It neither extends busy nor counts as a conversion for the code ramp.
- R4: Holding conv_start high does not start a further conversion. Only a new low-to-high change does.
- R5: An accepted convert edge captures the code for channel k (k = 0 for channel 1 through 7 for channel 8) as (CH_BASE + k*CH_STEP + n*FRAME_STEP) mod 2^16. Here n is the number of conversions accepted since reset, before this one. With RAMP = 0 the n term is dropped. The defaults are CH_BASE 0xF000, CH_STEP 0x0400 and FRAME_STEP 0x0013.
- R6: A read-strobe falling edge while busy is high leaves the data bus unchanged and does not advance the channel index.
- R7: Each falling edge of rd_n, while cs_n is 0 and busy is 0, puts the code of the current channel on the bus, visible after that clock edge. Successive reads go from channel 1 to channel 8 in order.
- R8: first_word is 1 exactly while the bus holds the word read for channel 1. Any other read clears it.
- R9: A falling edge of rd_n while cs_n is 1 changes neither the bus nor the channel index.
- R10: After channel 8 has been read, the next read returns channel 1 with WRAP = 1, or channel 8 again (first_word 0) with WRAP = 0.
- R11: Each accepted conversion resets the channel index, so the first read after it returns channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Shared convert-start; a rising edge begins a conversion |
| cs_n | input | 1 | Active-low chip select for readout |
| rd_n | input | 1 | Read strobe; a falling edge fetches the next channel |
| busy | output | 1 | High during a conversion |
| data_bus | output | 16 | Two's-complement channel code last read |
| first_word | output | 1 | High while data_bus holds channel 1 |

## Verification
Busy reads 1 one clock edge after the convert edge is clocked in, and reads 0 exactly CONV_CYCLES edges later. A data word appears one edge after the clock that samples rd_n low. The bench changes every input on the falling clock edge and samples on the next falling edge, so each result is read exactly one register stage after its cause. The busy window is counted sample by sample, and the ignored stimuli are applied in the middle of that window. Two instances, one per end-of-readout variant, receive the same stimuli so that both variants of R10 are compared in the same cycle.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        CV_IDLE    = 2'd0,
        CV_CONVERT = 2'd1,
        CV_READY   = 2'd2
    } conv_state_e;

endpackage

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl
    import sadc_pkg::*;
#(
    parameter int CONV_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    output logic busy,
    output logic accept
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    conv_state_e      state_q, state_d;
    logic             start_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic             expire;

    assign rise   = conv_start & ~start_q;
    assign expire = (cnt_q == '0);

    // edge detector: reset high so only a genuine low-to-high change counts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= 1'b1;
        else        start_q <= conv_start;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CV_IDLE;
        else        state_q <= state_d;
    end

    // next state and accept
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            CV_IDLE, CV_READY: begin
                if (rise) begin
                    state_d = CV_CONVERT;
                    accept  = 1'b1;
                end
            end
            CV_CONVERT: begin
                if (expire) state_d = CV_READY;
            end
            default: state_d = CV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == CV_CONVERT);
    end

    // conversion timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= CNT_LOAD;
        end else if (state_q == CV_CONVERT && !expire) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) && !busy |=> busy);

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !expire |=> busy);

    assert_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) && busy && !expire |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/sadc_sample_bank.sv
module sadc_sample_bank #(
    parameter int NUM_CH     = 8,
    parameter int CODE_W     = 16,
    parameter bit RAMP       = 1'b1,
    parameter int CH_BASE    = 32'h0000_F000,
    parameter int CH_STEP    = 32'h0000_0400,
    parameter int FRAME_STEP = 32'h0000_0013
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture,
    output logic [NUM_CH-1:0][CODE_W-1:0] codes
);

    logic [CODE_W-1:0] ramp_term;

    generate
        if (RAMP) begin : g_ramp
            logic [CODE_W-1:0] frame_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       frame_q <= '0;
                else if (capture) frame_q <= frame_q + 1'b1;
            end
            assign ramp_term = CODE_W'(frame_q * CODE_W'(FRAME_STEP));
        end else begin : g_fixed
            assign ramp_term = '0;
        end
    endgenerate

    // all channels are captured on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            codes <= '0;
        end else if (capture) begin
            for (int i = 0; i < NUM_CH; i++) begin
                codes[i] <= CODE_W'(CH_BASE + i * CH_STEP) + ramp_term;
            end
        end
    end

    assert_codes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(codes));

endmodule

// File: rtl/sadc_readout.sv
module sadc_readout #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 16,
    parameter bit WRAP   = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restart,
    input  logic                          busy,
    input  logic                          cs_n,
    input  logic                          rd_n,
    input  logic [NUM_CH-1:0][CODE_W-1:0] codes,
    output logic [CODE_W-1:0]             data_bus,
    output logic                          first_word
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CH - 1);

    logic             rd_q;
    logic [IDX_W-1:0] idx_q, idx_next;
    logic             read_ok;
    logic             last;

    assign read_ok = rd_q & ~rd_n & ~cs_n & ~busy;
    assign last    = (idx_q == IDX_LAST);

    generate
        if (WRAP) begin : g_wrap
            always_comb idx_next = last ? '0 : idx_q + 1'b1;
        end else begin : g_hold
            always_comb idx_next = last ? idx_q : idx_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            data_bus   <= '0;
            first_word <= 1'b0;
        end else if (restart) begin
            idx_q <= '0;
        end else if (read_ok) begin
            data_bus   <= codes[idx_q];
            first_word <= (idx_q == '0);
            idx_q      <= idx_next;
        end
    end

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);

    assert_bus_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(data_bus) && $stable(first_word));

    assert_cs_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && !restart |=> $stable(idx_q) && $stable(data_bus));

    assert_first_ch1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first_word) |-> idx_q == IDX_W'(1 % NUM_CH));

endmodule

// File: rtl/sadc_emu.sv
module sadc_emu #(
    parameter int NUM_CH      = 8,
    parameter int CODE_W      = 16,
    parameter int CONV_CYCLES = 200,
    parameter bit WRAP        = 1'b1,
    parameter bit RAMP        = 1'b1,
    parameter int CH_BASE     = 32'h0000_F000,
    parameter int CH_STEP     = 32'h0000_0400,
    parameter int FRAME_STEP  = 32'h0000_0013
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              busy,
    output logic [CODE_W-1:0] data_bus,
    output logic              first_word
);

    logic                          accept;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    sadc_conv_ctrl #(
        .CONV_CYCLES(CONV_CYCLES)
    ) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_start(conv_start),
        .busy      (busy),
        .accept    (accept)
    );

    sadc_sample_bank #(
        .NUM_CH    (NUM_CH),
        .CODE_W    (CODE_W),
        .RAMP      (RAMP),
        .CH_BASE   (CH_BASE),
        .CH_STEP   (CH_STEP),
        .FRAME_STEP(FRAME_STEP)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(accept),
        .codes  (codes)
    );

    sadc_readout #(
        .NUM_CH(NUM_CH),
        .CODE_W(CODE_W),
        .WRAP  (WRAP)
    ) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .busy      (busy),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .codes     (codes),
        .data_bus  (data_bus),
        .first_word(first_word)
    );

endmodule

// File: tb/tb_sadc_emu.sv
`timescale 1ns / 1ps
module tb_sadc_emu;

    localparam int C     = 200;
    localparam int BASE  = 'hF000;
    localparam int STEP  = 'h0400;
    localparam int FSTEP = 'h0013;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic cs_n = 1'b1;
    logic rd_n = 1'b1;

    logic        busy, busy_h;
    logic [15:0] db, db_h;
    logic        fw, fw_h;

    int checks = 0;
    int fails = 0;
    int accepted = 0;

    always #5 clk = ~clk;

    // wrap + ramp variant
    sadc_emu #(.CONV_CYCLES(C), .WRAP(1'b1), .RAMP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
        .busy(busy), .data_bus(db), .first_word(fw));

    // hold + fixed-code variant
    sadc_emu #(.CONV_CYCLES(C), .WRAP(1'b0), .RAMP(1'b0)) dut_hold (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
        .busy(busy_h), .data_bus(db_h), .first_word(fw_h));

    function automatic logic [15:0] exp_code(int ch, int frame, bit ramp);
        return 16'(BASE + ch * STEP + (ramp ? frame * FSTEP : 0));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // one read: strobe low on a falling clock edge, result sampled one cycle later
    task automatic do_read(input bit sel);
        @(negedge clk);
        cs_n = ~sel;
        rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        cs_n = 1'b1;
    endtask

    task automatic read_expect(string req, int ch, int ch_h, int frame);
        do_read(1'b1);
        chk(req, "wrap data", db, exp_code(ch, frame, 1'b1));
        chk(req, "wrap first", fw, (ch == 0));
        chk(req, "hold data", db_h, exp_code(ch_h, 0, 1'b0));
        chk(req, "hold first", fw_h, (ch_h == 0));
    endtask

    // conversion with busy window counted; optional stimuli inside the window
    task automatic run_conv(input bit inject, input bit keep_high);
        int hi = 0;
        logic [15:0] snap = 16'h0;
        logic [15:0] snap_h = 16'h0;
        @(negedge clk);
        conv_start = 1'b1;
        for (int j = 1; j <= C + 1; j++) begin
            @(negedge clk);
            if (j == 1 && !keep_high) conv_start = 1'b0;
            if (j == 1) begin
                chk("R2", "busy after edge", busy, 1'b1);
                chk("R2", "hold busy after edge", busy_h, 1'b1);
            end
            if (inject && j == 40) conv_start = 1'b1;   // R3: edge during busy
            if (inject && j == 41) conv_start = 1'b0;
            if (inject && j == 60) begin                 // R6: read during busy
                snap = db; snap_h = db_h; cs_n = 1'b0; rd_n = 1'b0;
            end
            if (inject && j == 61) begin
                chk("R6", "bus during busy", db, snap);
                chk("R6", "hold bus during busy", db_h, snap_h);
                rd_n = 1'b1; cs_n = 1'b1;
            end
            if (busy) hi++;
            if (j == C + 1) begin
                chk("R2", "busy after window", busy, 1'b0);
                chk("R2", "hold busy after window", busy_h, 1'b0);
            end
        end
        chk(inject ? "R3" : "R2", "busy length", hi, C);
        accepted++;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 1'b0);
        chk("R1", "bus in reset", db, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "bus", db, 16'h0);
        chk("R1", "first", fw, 1'b0);
        chk("R1", "hold bus", db_h, 16'h0);
    endtask

    task automatic t_full_readout();
        run_conv(1'b0, 1'b0);
        for (int ch = 0; ch < 8; ch++) read_expect("R7", ch, ch, 0);  // R5 R8
        read_expect("R10", 0, 7, 0);
    endtask

    task automatic t_busy_ignore();
        run_conv(1'b1, 1'b0);
        read_expect("R3", 0, 0, 1);   // frame 1, index untouched by the busy read (R6)
    endtask

    task automatic t_cs_high();
        do_read(1'b0);
        chk("R9", "bus with cs high", db, exp_code(0, 1, 1'b1));
        chk("R9", "first with cs high", fw, 1'b1);
        read_expect("R9", 1, 1, 1);
        read_expect("R5", 2, 2, 1);
    endtask

    task automatic t_restart();
        run_conv(1'b0, 1'b0);
        read_expect("R11", 0, 0, 2);
    endtask

    task automatic t_level();
        run_conv(1'b0, 1'b1);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (busy) chk("R4", "no restart on level", busy, 1'b0);
        end
        chk("R4", "busy low while held", busy, 1'b0);
        conv_start = 1'b0;
        read_expect("R4", 0, 0, 3);
        read_expect("R5", 1, 1, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_full_readout();
        t_busy_ignore();
        t_cs_high();
        t_restart();
        t_level();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule